// File: doc/BRIEF.md
# Unaligned Word Load/Store Merger

This block does the byte merging for the four partial-word instructions that let a 32-bit value be loaded from, or stored to, an address that is not word aligned. Each such access touches only the one aligned word that holds the addressed byte. A load shifts bytes of that memory word into one end of the old register value and keeps the remaining register bytes. A store shifts bytes of the register into one end of the memory word and keeps the remaining memory bytes. A store therefore needs the old word: the caller reads it at the aligned address, and the block returns the merged word to write back there.

The caller presents one request per cycle. A request carries the operation, the base register value, the 16-bit signed offset, the destination register index (used by loads), the register value and the aligned memory word. One clock later the block presents the aligned address, the merged word and the enables that tell the caller what to do with them. A little-endian program reads a full unaligned word with a pair: the right-hand load at the first byte's address and the left-hand load at that address plus three.

Top module: `unal_merge`

## Requirements
- R1: The effective address is in_base plus in_offset sign-extended to 32 bits. out_addr is that address with bits [1:0] forced to zero. The byte offset k used below is bits [1:0] of the effective address.
- R2: Operation code 2'b00 (left load) gives out_data = (mem << 8*(3-k)) | (reg & ~(32'hFFFFFFFF << 8*(3-k))). For k = 3 this is the whole memory word.
- R3: Operation code 2'b01 (right load) gives out_data = (mem >> 8*k) | (reg & ~(32'hFFFFFFFF >> 8*k)). For k = 0 this is the whole memory word.
- R4: Operation code 2'b10 (left store) gives out_data = (reg >> 8*(3-k)) | (mem & ~(32'hFFFFFFFF >> 8*(3-k))). For k = 3 this is the whole register.
- R5: Operation code 2'b11 (right store) gives out_data = (reg << 8*k) | (mem & ~(32'hFFFFFFFF << 8*k)). For k = 0 this is the whole register.
- R6: A valid load with a nonzero destination raises out_reg_we. A valid store raises out_mem_we. The two are never high together. A store never raises out_reg_we.
- R7: A valid load to destination 0 still raises out_mem_re, but out_reg_we stays low. out_mem_re is high for every valid request, since all four operations read the aligned word.
- R8: Results appear one clock after the request. In a cycle following in_valid low, all three enables are low, and out_addr, out_data and out_dst keep their previous values.
- R9: While reset is held, every output is zero.
- R10: A left load at the word after an unaligned address, followed by a right load at that address whose register input is the first result, yields the full unaligned little-endian word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request present this cycle |
| in_op | input | 2 | Operation: 00 left load, 01 right load, 10 left store, 11 right store |
| in_base | input | 32 | Base register value |
| in_offset | input | 16 | Signed address offset |
| in_dst | input | 5 | Load destination register index |
| in_reg | input | 32 | Register value (old destination for loads, source for stores) |
| in_mem | input | 32 | Aligned memory word |
| out_addr | output | 32 | Aligned word address |
| out_data | output | 32 | Merged register value or merged memory word |
| out_mem_re | output | 1 | Aligned word is read |
| out_reg_we | output | 1 | Write out_data to register out_dst |
| out_mem_we | output | 1 | Write out_data to memory at out_addr |
| out_dst | output | 5 | Destination index carried with the result |

## Verification
The merge is driven with one memory word and one register value whose eight bytes are all distinct, across every operation and every byte offset. Any swapped lane, wrong shift direction or wrong mask therefore shows up as a misplaced byte. Negative offsets that cross a word boundary test the sign extension and the alignment. The zero-destination load and idle cycles with changed inputs separate the read, write and hold behaviour. A left/right load pair over two words with distinct bytes confirms that the two halves reassemble the unaligned word.

// File: rtl/unal_pkg.sv
package unal_pkg;
    typedef enum logic [1:0] {
        MRG_LOAD_LEFT   = 2'b00,
        MRG_LOAD_RIGHT  = 2'b01,
        MRG_STORE_LEFT  = 2'b10,
        MRG_STORE_RIGHT = 2'b11
    } merge_op_e;
endpackage

// File: rtl/unal_addr_gen.sv
module unal_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int LANE_W = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [OFF_W-1:0]  offset,
    output logic [ADDR_W-1:0] aligned,
    output logic [LANE_W-1:0] lane
);
    logic [ADDR_W-1:0] eff;

    always_comb begin
        eff     = base + {{(ADDR_W-OFF_W){offset[OFF_W-1]}}, offset};
        aligned = {eff[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
        lane    = eff[LANE_W-1:0];
    end
endmodule

// File: rtl/unal_byte_merge.sv
module unal_byte_merge #(
    parameter int W    = 32,
    parameter int SH_W = 5,
    parameter bit UP   = 1'b1
) (
    input  logic [W-1:0]    src,
    input  logic [W-1:0]    keep,
    input  logic [SH_W-1:0] sh_bits,
    output logic [W-1:0]    res
);
    localparam logic [W-1:0] ONES = {W{1'b1}};

    generate
        if (UP) begin : g_up
            always_comb res = (src << sh_bits) | (keep & ~(ONES << sh_bits));
        end else begin : g_down
            always_comb res = (src >> sh_bits) | (keep & ~(ONES >> sh_bits));
        end
    endgenerate
endmodule

// File: rtl/unal_merge.sv
module unal_merge
    import unal_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 16,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_op,
    input  logic [ADDR_W-1:0] in_base,
    input  logic [OFF_W-1:0]  in_offset,
    input  logic [IDX_W-1:0]  in_dst,
    input  logic [DATA_W-1:0] in_reg,
    input  logic [DATA_W-1:0] in_mem,
    output logic [ADDR_W-1:0] out_addr,
    output logic [DATA_W-1:0] out_data,
    output logic              out_mem_re,
    output logic              out_reg_we,
    output logic              out_mem_we,
    output logic [IDX_W-1:0]  out_dst
);
    localparam int NBYTES = DATA_W / 8;
    localparam int LANE_W = $clog2(NBYTES);
    localparam int SH_W   = LANE_W + 3;
    localparam logic [LANE_W-1:0] TOP_LANE = LANE_W'(NBYTES - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              re;
        logic              rwe;
        logic              mwe;
        logic [IDX_W-1:0]  dst;
    } st_t;

    st_t st_d, st_q;

    logic [ADDR_W-1:0] aligned;
    logic [LANE_W-1:0] lane;
    logic [SH_W-1:0]   sh_hi, sh_lo;
    logic [DATA_W-1:0] ld_left, ld_right, st_left, st_right;
    merge_op_e         op;

    unal_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .LANE_W(LANE_W)) u_addr (
        .base(in_base), .offset(in_offset), .aligned(aligned), .lane(lane)
    );

    assign sh_hi = {TOP_LANE - lane, 3'b000};
    assign sh_lo = {lane, 3'b000};

    unal_byte_merge #(.W(DATA_W), .SH_W(SH_W), .UP(1'b1)) u_ld_left (
        .src(in_mem), .keep(in_reg), .sh_bits(sh_hi), .res(ld_left)
    );
    unal_byte_merge #(.W(DATA_W), .SH_W(SH_W), .UP(1'b0)) u_ld_right (
        .src(in_mem), .keep(in_reg), .sh_bits(sh_lo), .res(ld_right)
    );
    unal_byte_merge #(.W(DATA_W), .SH_W(SH_W), .UP(1'b0)) u_st_left (
        .src(in_reg), .keep(in_mem), .sh_bits(sh_hi), .res(st_left)
    );
    unal_byte_merge #(.W(DATA_W), .SH_W(SH_W), .UP(1'b1)) u_st_right (
        .src(in_reg), .keep(in_mem), .sh_bits(sh_lo), .res(st_right)
    );

    always_comb begin
        op   = merge_op_e'(in_op);
        st_d = st_q;
        st_d.re  = 1'b0;
        st_d.rwe = 1'b0;
        st_d.mwe = 1'b0;
        if (in_valid) begin
            st_d.addr = aligned;
            st_d.dst  = in_dst;
            st_d.re   = 1'b1;
            unique case (op)
                MRG_LOAD_LEFT:   st_d.data = ld_left;
                MRG_LOAD_RIGHT:  st_d.data = ld_right;
                MRG_STORE_LEFT:  st_d.data = st_left;
                default:         st_d.data = st_right;
            endcase
            if (op == MRG_STORE_LEFT || op == MRG_STORE_RIGHT) begin
                st_d.mwe = 1'b1;
            end else begin
                st_d.rwe = (in_dst != '0);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_addr   = st_q.addr;
    assign out_data   = st_q.data;
    assign out_mem_re = st_q.re;
    assign out_reg_we = st_q.rwe;
    assign out_mem_we = st_q.mwe;
    assign out_dst    = st_q.dst;
endmodule

// File: rtl/unal_merge_chk.sv
module unal_merge_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        in_op,
    input logic [IDX_W-1:0]  in_dst,
    input logic [ADDR_W-1:0] out_addr,
    input logic [DATA_W-1:0] out_data,
    input logic              out_mem_re,
    input logic              out_reg_we,
    input logic              out_mem_we
);
    p_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_addr[1:0] == 2'b00);

    p_we_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_reg_we && out_mem_we));

    p_store_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op[1]) |=> (out_mem_we && !out_reg_we));

    p_zero_dst_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_op[1] && in_dst == '0) |=> (out_mem_re && !out_reg_we));

    p_idle_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_mem_re && !out_reg_we && !out_mem_we));

    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_data) && $stable(out_addr)));
endmodule

bind unal_merge unal_merge_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/unal_merge_test.sv
module unal_merge_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_op = '0;
    logic [31:0] in_base = '0;
    logic [15:0] in_offset = '0;
    logic [4:0]  in_dst = '0;
    logic [31:0] in_reg = '0;
    logic [31:0] in_mem = '0;
    logic [31:0] out_addr, out_data;
    logic        out_mem_re, out_reg_we, out_mem_we;
    logic [4:0]  out_dst;

    int n_checks = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    unal_merge uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_base(in_base), .in_offset(in_offset), .in_dst(in_dst),
        .in_reg(in_reg), .in_mem(in_mem), .out_addr(out_addr),
        .out_data(out_data), .out_mem_re(out_mem_re), .out_reg_we(out_reg_we),
        .out_mem_we(out_mem_we), .out_dst(out_dst)
    );

    // {op, offset k, expected merged word}; mem = 11223344, reg = AABBCCDD
    typedef struct packed {
        logic [1:0]  op;
        logic [1:0]  k;
        logic [31:0] exp;
    } vec_t;

    localparam vec_t VECS [16] = '{
        '{2'b00, 2'd0, 32'h44BBCCDD}, '{2'b00, 2'd1, 32'h3344CCDD},
        '{2'b00, 2'd2, 32'h223344DD}, '{2'b00, 2'd3, 32'h11223344},
        '{2'b01, 2'd0, 32'h11223344}, '{2'b01, 2'd1, 32'hAA112233},
        '{2'b01, 2'd2, 32'hAABB1122}, '{2'b01, 2'd3, 32'hAABBCC11},
        '{2'b10, 2'd0, 32'h112233AA}, '{2'b10, 2'd1, 32'h1122AABB},
        '{2'b10, 2'd2, 32'h11AABBCC}, '{2'b10, 2'd3, 32'hAABBCCDD},
        '{2'b11, 2'd0, 32'hAABBCCDD}, '{2'b11, 2'd1, 32'hBBCCDD44},
        '{2'b11, 2'd2, 32'hCCDD3344}, '{2'b11, 2'd3, 32'hDD223344}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [1:0] op, input logic [31:0] base, input logic [15:0] off,
                         input logic [4:0] dst, input logic [31:0] rv, input logic [31:0] mv);
        in_valid = 1'b1; in_op = op; in_base = base; in_offset = off;
        in_dst = dst; in_reg = rv; in_mem = mv;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [31:0] saved;
        repeat (2) @(negedge clk);
        // R9: reset state
        check("R9 addr", out_addr, 32'h0);
        check("R9 data", out_data, 32'h0);
        check("R9 enables", {29'h0, out_mem_re, out_reg_we, out_mem_we}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2..R5, R1, R6: table walk
        for (int i = 0; i < 16; i++) begin
            apply(VECS[i].op, 32'h0000_1000, {14'h0, VECS[i].k}, 5'd9, 32'hAABBCCDD, 32'h11223344);
            case (VECS[i].op)
                2'b00: check("R2 left load", out_data, VECS[i].exp);
                2'b01: check("R3 right load", out_data, VECS[i].exp);
                2'b10: check("R4 left store", out_data, VECS[i].exp);
                default: check("R5 right store", out_data, VECS[i].exp);
            endcase
            check("R1 aligned addr", out_addr, 32'h0000_1000);
            if (VECS[i].op[1])
                check("R6 store enables", {30'h0, out_reg_we, out_mem_we}, 32'h1);
            else
                check("R6 load enables", {30'h0, out_reg_we, out_mem_we}, 32'h2);
            check("R7 read enable", {31'h0, out_mem_re}, 32'h1);
        end

        // R1: negative offset crosses word boundary: 0x2000 - 3 = 0x1FFD, k = 1
        apply(2'b01, 32'h0000_2000, 16'hFFFD, 5'd4, 32'hAABBCCDD, 32'h11223344);
        check("R1 negative offset addr", out_addr, 32'h0000_1FFC);
        check("R3 negative offset lane", out_data, 32'hAA112233);
        check("R6 dst carried", {27'h0, out_dst}, 32'd4);

        // R7: load to register 0
        apply(2'b00, 32'h0000_3000, 16'h0002, 5'd0, 32'hAABBCCDD, 32'h11223344);
        check("R7 zero dst no write", {31'h0, out_reg_we}, 32'h0);
        check("R7 zero dst still reads", {31'h0, out_mem_re}, 32'h1);
        check("R7 zero dst addr", out_addr, 32'h0000_3000);

        // R8: idle holds outputs, enables drop
        saved = out_data;
        in_valid = 1'b0; in_op = 2'b11; in_base = 32'h5555_0000;
        in_reg = 32'h0; in_mem = 32'hFFFF_FFFF; in_dst = 5'd7;
        @(negedge clk);
        check("R8 idle data hold", out_data, saved);
        check("R8 idle addr hold", out_addr, 32'h0000_3000);
        check("R8 idle enables", {29'h0, out_mem_re, out_reg_we, out_mem_we}, 32'h0);

        // R10: unaligned word at 0x101; words 0x100=44332211, 0x104=88776655
        apply(2'b00, 32'h0000_0101, 16'h0003, 5'd2, 32'h0000_0000, 32'h88776655);
        check("R10 left half", out_data, 32'h5500_0000);
        check("R10 left addr", out_addr, 32'h0000_0104);
        saved = out_data;
        apply(2'b01, 32'h0000_0101, 16'h0000, 5'd2, saved, 32'h44332211);
        check("R10 full unaligned word", out_data, 32'h55443322);
        check("R10 right addr", out_addr, 32'h0000_0100);

        // R9: reset mid-run clears outputs
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset data", out_data, 32'h0);
        check("R9 reset addr", out_addr, 32'h0);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule